// File: doc/BRIEF.md
# Self-Timed Codec Link Reset and Sync Pulse Generator

This block drives the reset and frame-sync lines of an AC'97-style codec link when software sets one-shot command bits. A cold-reset command holds the active-low link reset low for a fixed minimum time. A warm-reset command holds the sync line high for a fixed minimum time. The warm pulse is meant to wake a codec whose bit clock has stopped in power-down, so it is timed only from the system clock. The block has no bit-clock input.

After either pulse ends, the block watches the codec-ready input through a synchronizer. When it sees the codec ready, it raises a sticky codec-ready interrupt event. That event stays set until software writes the end-of-interrupt register. Software only writes a bit to start a pulse. The hardware times the pulse and clears the command bit itself, and software can read that bit back to poll for completion.

Top module: `link_reset_ctl`

## Requirements
- R1: After synchronous reset, link_rst_n is 1, link_sync is 0, irq_codec_ready is 0, and reads of offsets 0xA0, 0xA4 and 0x90 return 0.
- R2: A write with bit 0 set to offset 0xA0 drives link_rst_n low from the cycle after the write edge, for exactly RST_CYC system clocks. RST_CYC is the reset time rounded up to whole cycles: 125 at the defaults of 125 MHz and 1000 ns.
- R3: A write with bit 0 set to offset 0xA4 drives link_sync high from the cycle after the write edge, for exactly SYNC_CYC system clocks. SYNC_CYC is 163 at the defaults of 125 MHz and 1300 ns. No codec clock is involved.
- R4: Bit 0 of a read at offset 0xA0 (cold) or 0xA4 (warm) is 1 while that pulse is active and 0 once it has ended.
- R5: A cold or warm request written while either pulse is active is ignored. The running pulse keeps its length and the other line does not move. link_rst_n low and link_sync high never occur together.
- R6: Once a pulse has ended, a codec_ready input that is high, as seen after SYNC_STAGES synchronizer flops, sets irq_codec_ready, which is also bit 5 of offset 0x90. The event never sets while a pulse is active.
- R7: irq_codec_ready stays set until a write to offset 0x98 with bit 1 set clears it. A write there with bit 1 clear has no effect.
- R8: When no reset sequence is pending, codec_ready has no effect on irq_codec_ready.
- R9: Writes with bit 0 clear to 0xA0 or 0xA4, and writes to any other offset, leave both link lines and the event unchanged.
- R10: A new request is accepted while the block waits for codec ready after a pulse. A cold request during that wait starts a full cold pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Combinational read data |
| codec_ready | input | 1 | Codec-ready indication, asynchronous to clk |
| link_rst_n | output | 1 | Active-low link reset to the codec |
| link_sync | output | 1 | Link frame-sync line to the codec |
| irq_codec_ready | output | 1 | Sticky codec-ready interrupt event |

## Verification
A wrong counter load or terminal compare shows up as a pulse that is one or more cycles too long or too short. The bench counts every active cycle of each pulse, so this error appears at the falling edge of that same pulse. A sequencer stuck in a pulse or wait state shows as a readback bit that never clears, or as an event that fires while no reset is pending or while a line is still active. An event that is set too early or too late is caught on the exact cycle after the pulse ends, when codec_ready is already high. A broken clear or sticky path shows in the first cycle after the end-of-interrupt write.

// File: rtl/link_rst_pkg.sv
`timescale 1ns/1ps
package link_rst_pkg;

    localparam logic [7:0] OFS_COLD = 8'hA0;
    localparam logic [7:0] OFS_WARM = 8'hA4;
    localparam logic [7:0] OFS_STAT = 8'h90;
    localparam logic [7:0] OFS_EOI  = 8'h98;

    localparam int CMD_BIT      = 0;
    localparam int STAT_RDY_BIT = 5;
    localparam int EOI_RDY_BIT  = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_COLD  = 2'd1,
        SEQ_WARM  = 2'd2,
        SEQ_WATCH = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic go_cold;
        logic go_warm;
        logic ack_rdy;
    } lrs_req_t;

    function automatic int ns_to_cycles(input int mhz, input int ns);
        return (mhz * ns + 999) / 1000;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lrs_decode.sv
`timescale 1ns/1ps
module lrs_decode
    import link_rst_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output lrs_req_t          req
);
    always_comb begin
        req         = '0;
        req.go_cold = wr_en && (wr_addr == ADDR_W'(OFS_COLD)) && wr_data[CMD_BIT];
        req.go_warm = wr_en && (wr_addr == ADDR_W'(OFS_WARM)) && wr_data[CMD_BIT];
        req.ack_rdy = wr_en && (wr_addr == ADDR_W'(OFS_EOI))  && wr_data[EOI_RDY_BIT];
    end
endmodule

// File: rtl/lrs_ready_sync.sv
`timescale 1ns/1ps
module lrs_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lrs_sequencer.sv
`timescale 1ns/1ps
module lrs_sequencer
    import link_rst_pkg::*;
#(
    parameter int RST_CYC  = 125,
    parameter int SYNC_CYC = 163,
    localparam int CNT_W   = $clog2(max_int(RST_CYC, SYNC_CYC) + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  lrs_req_t   req,
    input  logic       rdy_s,
    output seq_state_t state,
    output logic       ready_hit
);
    localparam logic [CNT_W-1:0] COLD_LOAD = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] WARM_LOAD = CNT_W'(SYNC_CYC - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        ready_hit = 1'b0;
        unique case (state_q)
            SEQ_IDLE, SEQ_WATCH: begin
                if (req.go_cold) begin
                    state_d = SEQ_COLD;
                    cnt_d   = COLD_LOAD;
                end else if (req.go_warm) begin
                    state_d = SEQ_WARM;
                    cnt_d   = WARM_LOAD;
                end else if (state_q == SEQ_WATCH && rdy_s) begin
                    state_d   = SEQ_IDLE;
                    ready_hit = 1'b1;
                end
            end
            SEQ_COLD, SEQ_WARM: begin
                if (cnt_q == '0) state_d = SEQ_WATCH;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/link_reset_ctl.sv
`timescale 1ns/1ps
module link_reset_ctl
    import link_rst_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYS_CLK_MHZ = 125,
    parameter int RESET_NS    = 1000,
    parameter int SYNC_NS     = 1300,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              codec_ready,
    output logic              link_rst_n,
    output logic              link_sync,
    output logic              irq_codec_ready
);
    localparam int RST_CYC  = ns_to_cycles(SYS_CLK_MHZ, RESET_NS);
    localparam int SYNC_CYC = ns_to_cycles(SYS_CLK_MHZ, SYNC_NS);

    lrs_req_t   req;
    seq_state_t state;
    logic       rdy_s;
    logic       ready_hit;
    logic       evt_q;

    lrs_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req)
    );

    lrs_ready_sync #(.STAGES(SYNC_STAGES)) u_rsync (
        .clk      (clk),
        .rst      (rst),
        .async_in (codec_ready),
        .sync_out (rdy_s)
    );

    lrs_sequencer #(.RST_CYC(RST_CYC), .SYNC_CYC(SYNC_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .rdy_s     (rdy_s),
        .state     (state),
        .ready_hit (ready_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)            evt_q <= 1'b0;
        else if (ready_hit) evt_q <= 1'b1;
        else if (req.ack_rdy) evt_q <= 1'b0;
    end

    assign link_rst_n      = (state != SEQ_COLD);
    assign link_sync       = (state == SEQ_WARM);
    assign irq_codec_ready = evt_q;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_COLD))      rd_data[CMD_BIT]      = (state == SEQ_COLD);
        else if (rd_addr == ADDR_W'(OFS_WARM)) rd_data[CMD_BIT]      = (state == SEQ_WARM);
        else if (rd_addr == ADDR_W'(OFS_STAT)) rd_data[STAT_RDY_BIT] = evt_q;
    end
endmodule

// File: rtl/link_reset_ctl_chk.sv
`timescale 1ns/1ps
module link_reset_ctl_chk
    import link_rst_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int RST_CYC  = 125,
    parameter int SYNC_CYC = 163
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              link_rst_n,
    input logic              link_sync,
    input logic              irq_codec_ready
);
    logic [23:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= link_rst_n ? 24'd0 : lo_cnt + 24'd1;
            hi_cnt <= link_sync  ? hi_cnt + 24'd1 : 24'd0;
        end
    end

    assert_cold_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(link_rst_n) |-> (lo_cnt == 24'(RST_CYC)));

    assert_cold_start_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(link_rst_n) |-> $past(wr_en && wr_addr == ADDR_W'(OFS_COLD) && wr_data[CMD_BIT]));

    assert_sync_width_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(link_sync) |-> (hi_cnt == 24'(SYNC_CYC)));

    assert_sync_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(link_sync) |-> $past(wr_en && wr_addr == ADDR_W'(OFS_WARM) && wr_data[CMD_BIT]));

    assert_lines_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(!link_rst_n && link_sync));

    assert_event_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_codec_ready) |-> (link_rst_n && !link_sync));

    assert_event_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_codec_ready) |-> $past(wr_en && wr_addr == ADDR_W'(OFS_EOI) && wr_data[EOI_RDY_BIT]));
endmodule

bind link_reset_ctl link_reset_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RST_CYC  (RST_CYC),
    .SYNC_CYC (SYNC_CYC)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .link_rst_n      (link_rst_n),
    .link_sync       (link_sync),
    .irq_codec_ready (irq_codec_ready)
);

// File: tb/sim_link_reset_ctl.sv
`timescale 1ns/1ps
module sim_link_reset_ctl;

    localparam int EXP_RST  = 125;
    localparam int EXP_SYNC = 163;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        codec_ready = 1'b0;
    logic        link_rst_n, link_sync, irq_codec_ready;

    int n_checks = 0;
    int n_errs   = 0;

    always #4 clk = ~clk;

    link_reset_ctl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .codec_ready(codec_ready),
        .link_rst_n(link_rst_n), .link_sync(link_sync), .irq_codec_ready(irq_codec_ready)
    );

    function automatic bit is_cmd(input logic [7:0] a, input logic [31:0] d);
        return ((a == 8'hA0 || a == 8'hA4) && d[0]) || (a == 8'h98 && d[1]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd_bit(input logic [7:0] a, input int b, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data[b]);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (!link_rst_n && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure_sync(output int n);
        n = 0;
        while (link_sync && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        int v, n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(link_rst_n == 1'b1, "R1 rst_n", int'(link_rst_n), 1);
        check(link_sync == 1'b0, "R1 sync", int'(link_sync), 0);
        check(irq_codec_ready == 1'b0, "R1 irq", int'(irq_codec_ready), 0);
        rd_bit(8'hA0, 0, v); check(v == 0, "R1 cold rb", v, 0);
        rd_bit(8'hA4, 0, v); check(v == 0, "R1 warm rb", v, 0);
        rd_bit(8'h90, 5, v); check(v == 0, "R1 stat rb", v, 0);

        // R2 cold pulse width, R4 readback
        wr(8'hA0, 32'h1);
        rd_bit(8'hA0, 0, v); check(v == 1, "R4 cold busy", v, 1);
        measure_low(n);
        check(n == EXP_RST, "R2 cold width", n, EXP_RST);
        rd_bit(8'hA0, 0, v); check(v == 0, "R4 cold done", v, 0);

        // R6 event only after codec ready
        repeat (5) @(negedge clk);
        check(irq_codec_ready == 1'b0, "R6 no ready yet", int'(irq_codec_ready), 0);
        codec_ready = 1'b1;
        repeat (4) @(negedge clk);
        check(irq_codec_ready == 1'b1, "R6 event set", int'(irq_codec_ready), 1);
        rd_bit(8'h90, 5, v); check(v == 1, "R6 stat bit5", v, 1);

        // R7 sticky, clear only with bit 1
        wr(8'h98, 32'h1);
        check(irq_codec_ready == 1'b1, "R7 bit1 clear keeps", int'(irq_codec_ready), 1);
        wr(8'h98, 32'h2);
        check(irq_codec_ready == 1'b0, "R7 cleared", int'(irq_codec_ready), 0);
        // R8 ready high while idle has no effect
        repeat (6) @(negedge clk);
        check(irq_codec_ready == 1'b0, "R8 idle ready", int'(irq_codec_ready), 0);

        // R3 warm pulse with ready already high; R6 exact timing
        wr(8'hA4, 32'h1);
        rd_bit(8'hA4, 0, v); check(v == 1, "R4 warm busy", v, 1);
        check(link_rst_n == 1'b1, "R3 rst_n untouched", int'(link_rst_n), 1);
        measure_sync(n);
        check(n == EXP_SYNC, "R3 sync width", n, EXP_SYNC);
        check(irq_codec_ready == 1'b0, "R6 not during pulse", int'(irq_codec_ready), 0);
        rd_bit(8'hA4, 0, v); check(v == 0, "R4 warm done", v, 0);
        @(negedge clk);
        check(irq_codec_ready == 1'b1, "R6 set cycle after end", int'(irq_codec_ready), 1);
        wr(8'h98, 32'h2);

        // R5 requests during active cold pulse ignored
        codec_ready = 1'b0;
        repeat (4) @(negedge clk);
        wr(8'hA0, 32'h1);
        n = 1;
        repeat (10) begin @(negedge clk); n++; end
        wr(8'hA4, 32'h1); n++;
        check(link_sync == 1'b0, "R5 warm ignored", int'(link_sync), 0);
        wr(8'hA0, 32'h1); n++;
        begin
            int rest;
            measure_low(rest);
            n = n + rest - 1;
        end
        check(n == EXP_RST, "R5 cold width kept", n, EXP_RST);
        check(link_sync == 1'b0, "R5 sync after", int'(link_sync), 0);

        // R10 cold accepted while waiting for ready
        repeat (3) @(negedge clk);
        wr(8'hA0, 32'h1);
        check(link_rst_n == 1'b0, "R10 cold in wait", int'(link_rst_n), 0);
        measure_low(n);
        check(n == EXP_RST, "R10 width", n, EXP_RST);
        codec_ready = 1'b1;
        repeat (4) @(negedge clk);
        check(irq_codec_ready == 1'b1, "R6 event after R10", int'(irq_codec_ready), 1);
        wr(8'h98, 32'h2);

        // R9 / R8 random non-command writes and ready toggles
        for (int i = 0; i < 300; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            a = 8'($urandom());
            d = $urandom();
            if (($urandom() & 3) == 0) a = (($urandom() & 1) != 0) ? 8'hA0 : 8'hA4;
            if (a == 8'hA0 || a == 8'hA4) d[0] = 1'b0;
            if (a == 8'h98) d[1] = 1'b0;
            if (!is_cmd(a, d)) begin
                codec_ready = 1'($urandom());
                wr(a, d);
                check(link_rst_n == 1'b1 && link_sync == 1'b0, "R9 lines idle",
                      int'({link_rst_n, link_sync}), 2);
                check(irq_codec_ready == 1'b0, "R8 event quiet", int'(irq_codec_ready), 0);
            end
        end

        // Random order pulse mix
        for (int k = 0; k < 4; k++) begin
            codec_ready = 1'b0;
            repeat (3) @(negedge clk);
            if (($urandom() & 1) != 0) begin
                wr(8'hA0, 32'h1);
                measure_low(n);
                check(n == EXP_RST, "R2 random cold", n, EXP_RST);
            end else begin
                wr(8'hA4, 32'h1);
                measure_sync(n);
                check(n == EXP_SYNC, "R3 random warm", n, EXP_SYNC);
            end
            codec_ready = 1'b1;
            repeat (4) @(negedge clk);
            check(irq_codec_ready == 1'b1, "R6 random event", int'(irq_codec_ready), 1);
            wr(8'h98, 32'h2);
            check(irq_codec_ready == 1'b0, "R7 random clear", int'(irq_codec_ready), 0);
        end

        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule